// File: doc/BRIEF.md
# Strided 2D DMA Engine

This block moves rectangular byte blocks between a byte-addressed main memory (DRAM side) and a 4 KB on-chip scratch memory. The scratch memory is split into two banks, one holding instructions and one holding data. Software programs three values through a plain register write port: a scratch address (with one bit picking the bank), a DRAM address, and a packed shape word. The shape word carries the bytes per row, the number of rows, and a gap that is added to the DRAM address between rows. Which of the two shape slots is written picks the direction and starts the copy.

The engine visits every byte of the rectangle in order. For each byte it reads the source side, waits for the read data, then writes the destination side. Both addresses step by one byte inside a row. At the end of each row only the DRAM address also jumps by the gap, so a packed block in scratch memory maps onto a strided block in DRAM.

Both memory sides use the same stream handshake. A request is taken on a clock edge where its `valid` and `ready` are both high. While `valid` is high and `ready` is low, the request and all of its fields stay unchanged. At most one read is outstanding. A read request that has been taken is answered by exactly one `rsp_valid` pulse, at least one cycle later. Responses cannot be back-pressured. Write requests receive no response.

Top module: `rect_dma2d_engine`

## Requirements
- R1: The bytes per row are `(shape[11:0] | 7) + 1`, so a row is always a multiple of 8 bytes (a field of 0 or 7 gives 8, a field of 8 or 13 gives 16, and 0xFFF gives 4096).
- R2: The number of rows is `shape[19:12] + 1`. The total number of bytes copied is the row count times the bytes per row.
- R3: `shape[31:20]` is a gap that is added to the DRAM address after each row, on top of the normal one-byte step. The scratch address never receives the gap, so scratch bytes are contiguous.
- R4: A scratch address write takes bits [11:0] as the byte offset and bit 12 as the bank (1 = instruction bank, driven as `lm_req_bank` = 1; 0 = data bank). The offset wraps modulo 4096, and the bank stays fixed for the whole transfer.
- R5: A DRAM address write takes only bits [23:0]. The DRAM address wraps modulo 2^24.
- R6: `cfg_sel` encodes the target: 0 = scratch address, 1 = DRAM address, 2 = inbound shape (copy DRAM to scratch), 3 = outbound shape (copy scratch to DRAM). A shape write while idle starts a transfer.
- R7: Byte k of a transfer is read from the source side at its k-th address and then written, unchanged, to the destination side at its k-th address. The source port carries only reads and the destination port carries only writes.
- R8: `busy` rises the cycle after an accepted shape write. It stays high until the final destination write is taken. On that same edge `busy` falls and `done` pulses high for exactly one cycle. While idle, no request is raised.
- R9: A shape write while `busy` is high is ignored. It does not change the running transfer and does not start another one.
- R10: After reset, the engine is idle with both request valids low. A pending request (valid high, ready low) holds all of its fields stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R6) |
| cfg_data | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| lm_req_valid | output | 1 | Scratch memory request valid |
| lm_req_ready | input | 1 | Scratch memory request ready |
| lm_req_we | output | 1 | Scratch request is a write |
| lm_req_bank | output | 1 | Scratch bank: 1 instruction, 0 data |
| lm_req_addr | output | 12 | Scratch byte offset |
| lm_req_wdata | output | 8 | Scratch write data |
| lm_rsp_valid | input | 1 | Scratch read data valid |
| lm_rsp_data | input | 8 | Scratch read data |
| dm_req_valid | output | 1 | DRAM request valid |
| dm_req_ready | input | 1 | DRAM request ready |
| dm_req_we | output | 1 | DRAM request is a write |
| dm_req_addr | output | 24 | DRAM byte address |
| dm_req_wdata | output | 8 | DRAM write data |
| dm_rsp_valid | input | 1 | DRAM read data valid |
| dm_rsp_data | input | 8 | DRAM read data |

## Verification
A wrong column or row counter shows up as a wrong byte count, or as a misplaced address at the first request after the row boundary it mishandles. A mishandled gap shows up on the very first request of the second row. A corrupted address register or bank bit appears on the next request it drives, which is at most a few handshake cycles later. The bench therefore compares every taken request with an arithmetic expectation at the moment it is taken, rather than only at the end of a transfer. Lost completion state appears as a missing or doubled `done` pulse, or as `busy` left high, and these are checked within a few cycles of the final write.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    CFG_LOCAL_ADDR = 2'd0,
    CFG_DRAM_ADDR  = 2'd1,
    CFG_SHAPE_IN   = 2'd2,
    CFG_SHAPE_OUT  = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } xfer_dir_e;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_RD_REQ,
    MV_RD_WAIT,
    MV_WR_REQ
  } mover_state_e;

endpackage

// File: rtl/dma2d_cfg_regs.sv
module dma2d_cfg_regs
  import dma2d_pkg::*;
#(
  parameter int LOCAL_AW = 12,
  parameter int DRAM_AW  = 24,
  parameter int COL_W    = 12,
  parameter int ROW_W    = 8,
  parameter int SKIP_W   = 12,
  parameter int CFG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_sel,
  input  logic [CFG_W-1:0]    cfg_data,
  input  logic                busy,
  output logic                start,
  output xfer_dir_e           start_dir,
  output logic                base_bank,
  output logic [LOCAL_AW-1:0] base_local,
  output logic [DRAM_AW-1:0]  base_dram,
  output logic [COL_W-1:0]    row_last,
  output logic [ROW_W-1:0]    rows_last,
  output logic [SKIP_W-1:0]   skip
);
  localparam int ROW_LSB  = COL_W;
  localparam int SKIP_LSB = COL_W + ROW_W;
  localparam int USED_W   = SKIP_LSB + SKIP_W;
  localparam logic [COL_W-1:0] ROUND_MASK = COL_W'(7);

  initial begin
    if (USED_W > CFG_W || DRAM_AW > CFG_W || LOCAL_AW + 1 > CFG_W)
      $error("dma2d_cfg_regs: field layout exceeds register width");
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_bank  <= 1'b0;
      base_local <= '0;
      base_dram  <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_LOCAL_ADDR: {base_bank, base_local} <= cfg_data[LOCAL_AW:0];
        CFG_DRAM_ADDR:  base_dram <= cfg_data[DRAM_AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    start     = cfg_wr && cfg_sel[1] && !busy;
    start_dir = cfg_sel[0] ? DIR_OUT : DIR_IN;
    row_last  = cfg_data[COL_W-1:0] | ROUND_MASK;
    rows_last = cfg_data[SKIP_LSB-1:ROW_LSB];
    skip      = cfg_data[USED_W-1:SKIP_LSB];
  end

endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
#(
  parameter int LOCAL_AW = 12,
  parameter int DRAM_AW  = 24,
  parameter int COL_W    = 12,
  parameter int ROW_W    = 8,
  parameter int SKIP_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  xfer_dir_e           start_dir,
  input  logic                start_bank,
  input  logic [LOCAL_AW-1:0] start_local,
  input  logic [DRAM_AW-1:0]  start_dram,
  input  logic [COL_W-1:0]    start_row_last,
  input  logic [ROW_W-1:0]    start_rows_last,
  input  logic [SKIP_W-1:0]   start_skip,
  input  logic                step,
  output logic                busy,
  output logic                done,
  output xfer_dir_e           cur_dir,
  output logic                cur_bank,
  output logic [LOCAL_AW-1:0] cur_local,
  output logic [DRAM_AW-1:0]  cur_dram,
  output logic                last_byte
);
  localparam logic [LOCAL_AW-1:0] LOCAL_ONE = LOCAL_AW'(1);
  localparam logic [DRAM_AW-1:0]  DRAM_ONE  = DRAM_AW'(1);
  localparam logic [COL_W-1:0]    COL_ONE   = COL_W'(1);
  localparam logic [ROW_W-1:0]    ROW_ONE   = ROW_W'(1);

  logic [COL_W-1:0]   col_q, row_last_q;
  logic [ROW_W-1:0]   row_q, rows_last_q;
  logic [SKIP_W-1:0]  skip_q;
  logic [DRAM_AW-1:0] skip_ext;
  logic               row_end;

  generate
    if (SKIP_W >= DRAM_AW) begin : g_skip_trunc
      logic unused_skip_hi;
      assign skip_ext = skip_q[DRAM_AW-1:0];
      assign unused_skip_hi = ^skip_q;
    end else begin : g_skip_ext
      assign skip_ext = {{(DRAM_AW-SKIP_W){1'b0}}, skip_q};
    end
  endgenerate

  assign row_end   = (col_q == row_last_q);
  assign last_byte = row_end && (row_q == rows_last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      cur_dir     <= DIR_IN;
      cur_bank    <= 1'b0;
      cur_local   <= '0;
      cur_dram    <= '0;
      col_q       <= '0;
      row_q       <= '0;
      row_last_q  <= '0;
      rows_last_q <= '0;
      skip_q      <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy        <= 1'b1;
        cur_dir     <= start_dir;
        cur_bank    <= start_bank;
        cur_local   <= start_local;
        cur_dram    <= start_dram;
        col_q       <= '0;
        row_q       <= '0;
        row_last_q  <= start_row_last;
        rows_last_q <= start_rows_last;
        skip_q      <= start_skip;
      end else if (busy && step) begin
        cur_local <= cur_local + LOCAL_ONE;
        if (row_end) begin
          col_q    <= '0;
          cur_dram <= cur_dram + DRAM_ONE + skip_ext;
          if (last_byte) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            row_q <= row_q + ROW_ONE;
          end
        end else begin
          col_q    <= col_q + COL_ONE;
          cur_dram <= cur_dram + DRAM_ONE;
        end
      end
    end
  end

endmodule

// File: rtl/dma2d_mover.sv
module dma2d_mover
  import dma2d_pkg::*;
#(
  parameter int LOCAL_AW = 12,
  parameter int DRAM_AW  = 24,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  xfer_dir_e           cur_dir,
  input  logic                cur_bank,
  input  logic [LOCAL_AW-1:0] cur_local,
  input  logic [DRAM_AW-1:0]  cur_dram,
  input  logic                last_byte,
  output logic                step,
  output logic                lm_req_valid,
  input  logic                lm_req_ready,
  output logic                lm_req_we,
  output logic                lm_req_bank,
  output logic [LOCAL_AW-1:0] lm_req_addr,
  output logic [DATA_W-1:0]   lm_req_wdata,
  input  logic                lm_rsp_valid,
  input  logic [DATA_W-1:0]   lm_rsp_data,
  output logic                dm_req_valid,
  input  logic                dm_req_ready,
  output logic                dm_req_we,
  output logic [DRAM_AW-1:0]  dm_req_addr,
  output logic [DATA_W-1:0]   dm_req_wdata,
  input  logic                dm_rsp_valid,
  input  logic [DATA_W-1:0]   dm_rsp_data
);
  mover_state_e state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic src_dram, rd_phase, wr_phase;
  logic src_ready, dst_ready, src_rsp_valid;
  logic [DATA_W-1:0] src_rsp_data;

  assign src_dram = (cur_dir == DIR_IN);
  assign rd_phase = (state_q == MV_RD_REQ);
  assign wr_phase = (state_q == MV_WR_REQ);

  always_comb begin
    lm_req_valid  = (rd_phase && !src_dram) || (wr_phase && src_dram);
    lm_req_we     = wr_phase;
    lm_req_bank   = cur_bank;
    lm_req_addr   = cur_local;
    lm_req_wdata  = data_q;
    dm_req_valid  = (rd_phase && src_dram) || (wr_phase && !src_dram);
    dm_req_we     = wr_phase;
    dm_req_addr   = cur_dram;
    dm_req_wdata  = data_q;
    src_ready     = src_dram ? dm_req_ready : lm_req_ready;
    dst_ready     = src_dram ? lm_req_ready : dm_req_ready;
    src_rsp_valid = src_dram ? dm_rsp_valid : lm_rsp_valid;
    src_rsp_data  = src_dram ? dm_rsp_data  : lm_rsp_data;
    step          = wr_phase && dst_ready;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      MV_IDLE:    if (start) state_d = MV_RD_REQ;
      MV_RD_REQ:  if (src_ready) state_d = MV_RD_WAIT;
      MV_RD_WAIT: if (src_rsp_valid) state_d = MV_WR_REQ;
      MV_WR_REQ:  if (dst_ready) state_d = last_byte ? MV_IDLE : MV_RD_REQ;
      default:    state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == MV_RD_WAIT && src_rsp_valid) data_q <= src_rsp_data;
    end
  end

endmodule

// File: rtl/rect_dma2d_engine.sv
module rect_dma2d_engine
  import dma2d_pkg::*;
#(
  parameter int LOCAL_AW = 12,
  parameter int DRAM_AW  = 24,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 12,
  parameter int ROW_W    = 8,
  parameter int SKIP_W   = 12,
  parameter int CFG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_sel,
  input  logic [CFG_W-1:0]    cfg_data,
  output logic                busy,
  output logic                done,
  output logic                lm_req_valid,
  input  logic                lm_req_ready,
  output logic                lm_req_we,
  output logic                lm_req_bank,
  output logic [LOCAL_AW-1:0] lm_req_addr,
  output logic [DATA_W-1:0]   lm_req_wdata,
  input  logic                lm_rsp_valid,
  input  logic [DATA_W-1:0]   lm_rsp_data,
  output logic                dm_req_valid,
  input  logic                dm_req_ready,
  output logic                dm_req_we,
  output logic [DRAM_AW-1:0]  dm_req_addr,
  output logic [DATA_W-1:0]   dm_req_wdata,
  input  logic                dm_rsp_valid,
  input  logic [DATA_W-1:0]   dm_rsp_data
);
  logic                start, base_bank, cur_bank, last_byte, step;
  xfer_dir_e           start_dir, cur_dir;
  logic [LOCAL_AW-1:0] base_local, cur_local;
  logic [DRAM_AW-1:0]  base_dram, cur_dram;
  logic [COL_W-1:0]    row_last;
  logic [ROW_W-1:0]    rows_last;
  logic [SKIP_W-1:0]   skip;

  dma2d_cfg_regs #(
    .LOCAL_AW(LOCAL_AW), .DRAM_AW(DRAM_AW), .COL_W(COL_W),
    .ROW_W(ROW_W), .SKIP_W(SKIP_W), .CFG_W(CFG_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .busy(busy), .start(start), .start_dir(start_dir),
    .base_bank(base_bank), .base_local(base_local), .base_dram(base_dram),
    .row_last(row_last), .rows_last(rows_last), .skip(skip)
  );

  dma2d_walker #(
    .LOCAL_AW(LOCAL_AW), .DRAM_AW(DRAM_AW), .COL_W(COL_W),
    .ROW_W(ROW_W), .SKIP_W(SKIP_W)
  ) walk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_bank(base_bank), .start_local(base_local), .start_dram(base_dram),
    .start_row_last(row_last), .start_rows_last(rows_last), .start_skip(skip),
    .step(step), .busy(busy), .done(done), .cur_dir(cur_dir),
    .cur_bank(cur_bank), .cur_local(cur_local), .cur_dram(cur_dram),
    .last_byte(last_byte)
  );

  dma2d_mover #(
    .LOCAL_AW(LOCAL_AW), .DRAM_AW(DRAM_AW), .DATA_W(DATA_W)
  ) move_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_dir(cur_dir),
    .cur_bank(cur_bank), .cur_local(cur_local), .cur_dram(cur_dram),
    .last_byte(last_byte), .step(step),
    .lm_req_valid(lm_req_valid), .lm_req_ready(lm_req_ready),
    .lm_req_we(lm_req_we), .lm_req_bank(lm_req_bank),
    .lm_req_addr(lm_req_addr), .lm_req_wdata(lm_req_wdata),
    .lm_rsp_valid(lm_rsp_valid), .lm_rsp_data(lm_rsp_data),
    .dm_req_valid(dm_req_valid), .dm_req_ready(dm_req_ready),
    .dm_req_we(dm_req_we), .dm_req_addr(dm_req_addr),
    .dm_req_wdata(dm_req_wdata), .dm_rsp_valid(dm_rsp_valid),
    .dm_rsp_data(dm_rsp_data)
  );

endmodule

// File: rtl/dma2d_chk.sv
module dma2d_chk #(
  parameter int LOCAL_AW = 12,
  parameter int DRAM_AW  = 24,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_wr,
  input logic [1:0]          cfg_sel,
  input logic                busy,
  input logic                done,
  input logic                lm_req_valid,
  input logic                lm_req_ready,
  input logic                lm_req_we,
  input logic                lm_req_bank,
  input logic [LOCAL_AW-1:0] lm_req_addr,
  input logic [DATA_W-1:0]   lm_req_wdata,
  input logic                dm_req_valid,
  input logic                dm_req_ready,
  input logic                dm_req_we,
  input logic [DRAM_AW-1:0]  dm_req_addr,
  input logic [DATA_W-1:0]   dm_req_wdata
);

  // R10
  lm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_req_valid && !lm_req_ready |=> lm_req_valid && $stable(lm_req_addr) &&
      $stable(lm_req_we) && $stable(lm_req_bank) && $stable(lm_req_wdata));

  // R10
  dm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req_valid && !dm_req_ready |=> dm_req_valid && $stable(dm_req_addr) &&
      $stable(dm_req_we) && $stable(dm_req_wdata));

  // R7
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lm_req_valid && dm_req_valid));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lm_req_valid && !dm_req_valid);

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_wr && cfg_sel[1]));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(lm_req_bank));

endmodule

bind rect_dma2d_engine dma2d_chk #(
  .LOCAL_AW(LOCAL_AW), .DRAM_AW(DRAM_AW), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/rect_dma2d_engine_tb_top.sv
module rect_dma2d_engine_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_data = 32'd0;
  logic        busy, done;
  logic        lm_req_valid, lm_req_we, lm_req_bank;
  logic        lm_req_ready = 1'b0;
  logic [11:0] lm_req_addr;
  logic [7:0]  lm_req_wdata;
  logic        lm_rsp_valid = 1'b0;
  logic [7:0]  lm_rsp_data = 8'd0;
  logic        dm_req_valid, dm_req_we;
  logic        dm_req_ready = 1'b0;
  logic [23:0] dm_req_addr;
  logic [7:0]  dm_req_wdata;
  logic        dm_rsp_valid = 1'b0;
  logic [7:0]  dm_rsp_data = 8'd0;
  logic        dm_s1_v = 1'b0;
  logic [7:0]  dm_s1_d = 8'd0;

  rect_dma2d_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .busy(busy), .done(done),
    .lm_req_valid(lm_req_valid), .lm_req_ready(lm_req_ready),
    .lm_req_we(lm_req_we), .lm_req_bank(lm_req_bank),
    .lm_req_addr(lm_req_addr), .lm_req_wdata(lm_req_wdata),
    .lm_rsp_valid(lm_rsp_valid), .lm_rsp_data(lm_rsp_data),
    .dm_req_valid(dm_req_valid), .dm_req_ready(dm_req_ready),
    .dm_req_we(dm_req_we), .dm_req_addr(dm_req_addr),
    .dm_req_wdata(dm_req_wdata), .dm_rsp_valid(dm_rsp_valid),
    .dm_rsp_data(dm_rsp_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  int t_dir = 0, t_bank = 0, t_local = 0, t_dram = 0;
  int t_rl = 8, t_rows = 1, t_skip = 0;
  int rd_cnt = 0, wr_cnt = 0, mism = 0, done_cnt = 0, hs_err = 0;
  logic       lm_hold_prev = 1'b0, dm_hold_prev = 1'b0;
  logic [11:0] lm_a_prev;
  logic [23:0] dm_a_prev;
  logic [7:0]  lm_d_prev, dm_d_prev;
  logic        lm_we_prev, lm_b_prev, dm_we_prev;

  function automatic logic [7:0] dram_pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] loc_pat(input logic b, input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 3'b011, b} ^ 8'h3C;
  endfunction

  function automatic logic [11:0] exp_loc(input int idx);
    return 12'(t_local + idx);
  endfunction

  function automatic logic [23:0] exp_dram(input int idx);
    int r, c;
    r = idx / t_rl;
    c = idx % t_rl;
    return 24'(t_dram + r * (t_rl + t_skip) + c);
  endfunction

  // stalls and memory models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    lm_req_ready <= (cyc % 4) != 2;
    dm_req_ready <= (cyc % 5) != 1;
    lm_rsp_valid <= 1'b0;
    if (lm_req_valid && lm_req_ready && !lm_req_we) begin
      lm_rsp_valid <= 1'b1;
      lm_rsp_data  <= loc_pat(lm_req_bank, lm_req_addr);
    end
    dm_s1_v      <= dm_req_valid && dm_req_ready && !dm_req_we;
    dm_s1_d      <= dram_pat(dm_req_addr);
    dm_rsp_valid <= dm_s1_v;
    dm_rsp_data  <= dm_s1_d;
  end

  // request monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (lm_req_valid && lm_req_ready) begin
        if (lm_req_we) begin
          if (t_dir != 0 || lm_req_bank != t_bank[0] || lm_req_addr != exp_loc(wr_cnt) ||
              lm_req_wdata != dram_pat(exp_dram(wr_cnt))) mism++;
          wr_cnt++;
        end else begin
          if (t_dir != 1 || lm_req_bank != t_bank[0] || lm_req_addr != exp_loc(rd_cnt)) mism++;
          rd_cnt++;
        end
      end
      if (dm_req_valid && dm_req_ready) begin
        if (dm_req_we) begin
          if (t_dir != 1 || dm_req_addr != exp_dram(wr_cnt) ||
              dm_req_wdata != loc_pat(t_bank[0], exp_loc(wr_cnt))) mism++;
          wr_cnt++;
        end else begin
          if (t_dir != 0 || dm_req_addr != exp_dram(rd_cnt)) mism++;
          rd_cnt++;
        end
      end
      if (lm_hold_prev && !(lm_req_valid && lm_req_addr == lm_a_prev && lm_req_we == lm_we_prev &&
          lm_req_bank == lm_b_prev && lm_req_wdata == lm_d_prev)) hs_err++;
      if (dm_hold_prev && !(dm_req_valid && dm_req_addr == dm_a_prev && dm_req_we == dm_we_prev &&
          dm_req_wdata == dm_d_prev)) hs_err++;
      lm_hold_prev = lm_req_valid && !lm_req_ready;
      dm_hold_prev = dm_req_valid && !dm_req_ready;
      lm_a_prev = lm_req_addr; lm_we_prev = lm_req_we; lm_b_prev = lm_req_bank; lm_d_prev = lm_req_wdata;
      dm_a_prev = dm_req_addr; dm_we_prev = dm_req_we; dm_d_prev = dm_req_wdata;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic start_xfer(input int dir, input int bank, input int loc,
                            input int dram, input logic [31:0] shape);
    t_dir = dir; t_bank = bank; t_local = loc; t_dram = dram;
    t_rl = int'(shape[11:0] | 12'd7) + 1;
    t_rows = int'(shape[19:12]) + 1;
    t_skip = int'(shape[31:20]);
    rd_cnt = 0; wr_cnt = 0; mism = 0; done_cnt = 0;
    cfg_write(2'd0, {16'hBEEF, 3'b101, bank[0], loc[11:0]});
    cfg_write(2'd1, {8'hC3, dram[23:0]});
    cfg_write({1'b1, dir[0]}, shape);
    check(busy == 1'b1, "R8 busy after shape write", busy, 1);
  endtask

  task automatic finish_xfer(input string tag);
    int n = 0;
    while (done_cnt == 0 && n < 30000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(wr_cnt == t_rl * t_rows, $sformatf("R1 R2 bytes written %s", tag), wr_cnt, t_rl * t_rows);
    check(rd_cnt == t_rl * t_rows, $sformatf("R7 bytes read %s", tag), rd_cnt, t_rl * t_rows);
    check(mism == 0, $sformatf("R3 R4 R5 R6 R7 address/data mismatches %s", tag), mism, 0);
    check(done_cnt == 1 && !busy, $sformatf("R8 single done pulse %s", tag), done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done && !lm_req_valid && !dm_req_valid, "R10 idle after reset",
          {busy, done, lm_req_valid, dm_req_valid}, 0);

    // sweep: direction, bank, row-length field, row count, skip (R1..R7)
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 2; b++) begin
        for (int ci = 0; ci < 4; ci++) begin
          for (int ri = 0; ri < 2; ri++) begin
            for (int si = 0; si < 2; si++) begin
              logic [11:0] colf;
              logic [7:0]  rowf;
              logic [11:0] skipf;
              colf  = (ci == 0) ? 12'd0 : (ci == 1) ? 12'd7 : (ci == 2) ? 12'd8 : 12'd13;
              rowf  = 8'(ri * 2);
              skipf = 12'(si * 5);
              start_xfer(d, b, b ? 12'hFFA : 12'h064, si ? 24'hFFFFF6 : 24'h001234,
                         {skipf, rowf, colf});
              finish_xfer($sformatf("dir%0d bank%0d col%0d rows%0d skip%0d",
                                    d, b, colf, rowf, skipf));
            end
          end
        end
      end
    end

    // R1 largest row: 4096 bytes, wraps the whole bank (R4)
    start_xfer(1, 0, 12'h010, 24'h020000, {12'd0, 8'd0, 12'hFFF});
    finish_xfer("R1 max row");

    // R3 large gap with several rows
    start_xfer(0, 1, 12'h300, 24'h00F000, {12'hFFF, 8'd3, 12'd20});
    finish_xfer("R3 big gap");

    // R9 shape write while busy must be ignored
    start_xfer(0, 0, 12'h200, 24'h004000, {12'd4, 8'd2, 12'd15});
    repeat (10) @(negedge clk);
    cfg_write(2'd3, 32'h0000_0FFF);
    cfg_write(2'd2, 32'h0010_2003);
    finish_xfer("R9 overlap");
    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      repeat (30) @(negedge clk);
      check(done_cnt == 1 && !busy && wr_cnt == w0 && rd_cnt == r0,
            "R9 no second transfer after ignored write", wr_cnt + rd_cnt, w0 + r0);
    end

    // R10 request stability under back-pressure
    check(hs_err == 0, "R10 pending request held stable", hs_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule